// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This peripheral serves three banks of 32 general-purpose pins through a flat 32-bit register port. For every pin, software chooses whether the pin drives its pad. It can load, set or clear the pin's output value, and it can invert the pin's input sense. It can also ask for an interrupt on a rising edge, a falling edge or both. The block passes each pin input through a two-flop synchronizer and compares the result with the value from the previous cycle. A detected edge on an enabled pin is held in a per-bank status register until software clears it by writing ones. A single interrupt line is high while any status bit in any bank is set.

The registers are interleaved by function. The upper nibble of the byte address picks the register kind, and bits [3:2] pick the bank. Software therefore reaches the same register of the three banks at addresses four bytes apart. Register kinds that are reserved read as zero and ignore writes, and so does the unused fourth bank slot.

Top module: `banked_gpio`

## Requirements
- R1: After reset every register is zero, `pin_oe`, `pin_out` and `irq` are low, and every register reads back as zero.
- R2: Byte address bits [7:4] select the register kind and bits [3:2] select the bank (0 to 2). The kind codes are 0 direction, 1 input inversion, 2 data, 3 set, 4 clear, 5 rising enable, 6 falling enable and 9 status. Direction, inversion and both enables read back exactly what was written.
- R3: A direction bit of 1 drives `pin_oe` high for pin bank*32+bit, and a 0 leaves that pin as an input.
- R4: A write to the set register drives high every output bit written as 1. A write to the clear register drives low every output bit written as 1. Bits written as 0 keep their output value in both cases.
- R5: A write to the data register loads all 32 output values of that bank at once, and `pin_out` follows on the next cycle.
- R6: A read of the data register returns the synchronized pin level XOR the bank's inversion bits. `bus_rdata` presents every read one clock after the request.
- R7: A rising edge on a pin whose rising-enable bit is 1 sets that pin's status bit, and so does a falling edge on a pin whose falling-enable bit is 1. An edge of a kind that is not enabled leaves the bit at 0.
- R8: Writing 1 to a status bit clears it. Status bits written as 0 stay set.
- R9: `irq` is high exactly while at least one status bit in any bank is set.
- R10: When a write-1 clear and a new enabled edge hit the same status bit in the same cycle, the bit stays set.
- R11: Kind codes 7, 8 and 10 to 15, and bank field 3, read as zero, and writes to them change no register or pin.
- R12: A pin change made between clock edges reaches the status bit, and `irq`, on the third rising clock edge after it and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_in | input | 96 | Raw pad input levels |
| pin_out | output | 96 | Output values |
| pin_oe | output | 96 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench raises a new edge on a status bit in exactly the cycle that a write-1 clear of that same bit lands. A design that let the clear win would lose that interrupt, and the status read that follows would come back zero. It also counts the clock edges between a pin change and `irq`, so a synchronizer one stage short or one stage long shows up. Writes of zero bits to the set, clear and status registers confirm that those bits stay untouched, which exposes a design that loads the written value instead. Finally, the bench writes all-ones to the reserved kinds and to the fourth bank slot and then reads them back and watches the pins, which catches an address decode that aliases onto real registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned KIND_LSB = 4;
  localparam int unsigned KIND_W   = 4;
  localparam int unsigned BANK_LSB = 2;
  localparam int unsigned BSEL_W   = 2;

  typedef enum logic [KIND_W-1:0] {
    K_DIR    = 4'd0,
    K_INV    = 4'd1,
    K_DATA   = 4'd2,
    K_SET    = 4'd3,
    K_CLR    = 4'd4,
    K_RISE   = 4'd5,
    K_FALL   = 4'd6,
    K_HI_RSV = 4'd7,
    K_LO_RSV = 4'd8,
    K_STAT   = 4'd9,
    K_CAP_RSV = 4'd10
  } reg_kind_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  input  logic [W-1:0] invert,
  output logic [W-1:0] level,
  output logic [W-1:0] rose,
  output logic [W-1:0] fell
);
  logic [W-1:0] meta_q, meta_n;
  logic [W-1:0] sync_q, sync_n;
  logic [W-1:0] prev_q, prev_n;

  assign level = sync_q ^ invert;
  assign rose  = level & ~prev_q;
  assign fell  = ~level & prev_q;

  always_comb begin
    meta_n = raw_in;
    sync_n = meta_q;
    prev_n = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_n;
      sync_q <= sync_n;
      prev_q <= prev_n;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] inv_o,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] stat_nxt_o,
  output logic [W-1:0] level_o
);
  logic [W-1:0] dir_q, dir_n;
  logic [W-1:0] dout_q, dout_n;
  logic [W-1:0] inv_q, inv_n;
  logic [W-1:0] ren_q, ren_n;
  logic [W-1:0] fen_q, fen_n;
  logic [W-1:0] stat_q, stat_n;
  logic [W-1:0] clr_mask;
  logic [W-1:0] rose, fell;

  gpio_edge_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (raw_in),
    .invert (inv_q),
    .level  (level_o),
    .rose   (rose),
    .fell   (fell)
  );

  always_comb begin
    dir_n    = dir_q;
    dout_n   = dout_q;
    inv_n    = inv_q;
    ren_n    = ren_q;
    fen_n    = fen_q;
    clr_mask = '0;
    if (wr_en) begin
      case (kind)
        K_DIR:  dir_n    = wdata;
        K_INV:  inv_n    = wdata;
        K_DATA: dout_n   = wdata;
        K_SET:  dout_n   = dout_q | wdata;
        K_CLR:  dout_n   = dout_q & ~wdata;
        K_RISE: ren_n    = wdata;
        K_FALL: fen_n    = wdata;
        K_STAT: clr_mask = wdata;
        default: ;
      endcase
    end
    // a fresh edge is ORed in after the clear, so it survives a same-cycle clear
    stat_n = (stat_q & ~clr_mask) | (rose & ren_q) | (fell & fen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      inv_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
    end else begin
      dir_q  <= dir_n;
      dout_q <= dout_n;
      inv_q  <= inv_n;
      ren_q  <= ren_n;
      fen_q  <= fen_n;
      stat_q <= stat_n;
    end
  end

  assign dir_o      = dir_q;
  assign dout_o     = dout_q;
  assign inv_o      = inv_q;
  assign rise_en_o  = ren_q;
  assign fall_en_o  = fen_q;
  assign stat_o     = stat_q;
  assign stat_nxt_o = stat_n;
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  reg_kind_e         kind;
  logic [BSEL_W-1:0] bank_f;
  logic              wr_req, rd_req;
  logic              unused_addr;

  logic [BANK_W-1:0] dir_a     [NUM_BANKS];
  logic [BANK_W-1:0] dout_a    [NUM_BANKS];
  logic [BANK_W-1:0] inv_a     [NUM_BANKS];
  logic [BANK_W-1:0] ren_a     [NUM_BANKS];
  logic [BANK_W-1:0] fen_a     [NUM_BANKS];
  logic [BANK_W-1:0] stat_a    [NUM_BANKS];
  logic [BANK_W-1:0] stat_nx_a [NUM_BANKS];
  logic [BANK_W-1:0] level_a   [NUM_BANKS];
  logic [PINS-1:0]   stat_all;
  logic [PINS-1:0]   stat_nxt_all;

  logic [BANK_W-1:0] rdata_q, rdata_n;
  logic              irq_q, irq_n;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign kind        = reg_kind_e'(bus_addr[KIND_LSB +: KIND_W]);
  assign bank_f      = bus_addr[BANK_LSB +: BSEL_W];
  assign wr_req      = bus_sel & bus_we;
  assign rd_req      = bus_sel & ~bus_we;
  assign unused_addr = ^bus_addr[BANK_LSB-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_req && (bank_f == BSEL_W'(b));

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .wr_en      (bank_wr),
      .kind       (kind),
      .wdata      (bus_wdata),
      .raw_in     (pin_in[b*BANK_W +: BANK_W]),
      .dir_o      (dir_a[b]),
      .dout_o     (dout_a[b]),
      .inv_o      (inv_a[b]),
      .rise_en_o  (ren_a[b]),
      .fall_en_o  (fen_a[b]),
      .stat_o     (stat_a[b]),
      .stat_nxt_o (stat_nx_a[b]),
      .level_o    (level_a[b])
    );

    assign pin_out[b*BANK_W +: BANK_W]      = dout_a[b];
    assign pin_oe[b*BANK_W +: BANK_W]       = dir_a[b];
    assign stat_all[b*BANK_W +: BANK_W]     = stat_a[b];
    assign stat_nxt_all[b*BANK_W +: BANK_W] = stat_nx_a[b];
  end

  always_comb begin
    rdata_n = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_f == BSEL_W'(b)) begin
        case (kind)
          K_DIR:  rdata_n = dir_a[b];
          K_INV:  rdata_n = inv_a[b];
          K_DATA: rdata_n = level_a[b];
          K_RISE: rdata_n = ren_a[b];
          K_FALL: rdata_n = fen_a[b];
          K_STAT: rdata_n = stat_a[b];
          default: rdata_n = '0;
        endcase
      end
    end
    irq_n = |stat_nxt_all;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_req) rdata_q <= rdata_n;
      irq_q <= irq_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk #(
  parameter int unsigned PINS   = 96,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned KLSB   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] stat_all,
  input logic          irq
);
  logic [3:0] k;
  logic       rsvd_rd;
  assign k       = bus_addr[KLSB +: 4];
  assign rsvd_rd = bus_sel && !bus_we && (k == 4'd7 || k == 4'd8 || k >= 4'd10);

  // R3
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we) |-> $stable(pin_oe));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we) |-> $stable(pin_out));

  // R8
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we) |-> ((stat_all & $past(stat_all)) == $past(stat_all)));

  // R9
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_all != '0));

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsvd_rd) |-> (bus_rdata == '0));
endmodule

bind banked_gpio banked_gpio_chk #(
  .PINS (PINS),
  .DW   (BANK_W),
  .AW   (gpio_pkg::ADDR_W),
  .KLSB (gpio_pkg::KIND_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .stat_all  (stat_all),
  .irq       (irq)
);

// File: tb/sim_banked_gpio.sv
`timescale 1ns/1ps
module sim_banked_gpio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  banked_gpio u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_sel && !bus_we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {64'h0, bus_rdata}, {64'h0, e});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", {95'h0, irq}, 96'h0);
    rd(8'h94, 32'h0, "R1 status bank1");

    // R2 / R3 direction register on bank 1
    wr(8'h04, 32'hF0F0_0000);
    rd(8'h04, 32'hF0F0_0000, "R2 dir readback");
    check("R3 pin_oe", pin_oe, {32'h0, 32'hF0F0_0000, 32'h0});
    rd(8'h00, 32'h0, "R2 dir bank0 untouched");

    // R4 set / clear with zero bits untouched
    wr(8'h30, 32'h0000_00FF);
    check("R4 set", pin_out[31:0], 96'h0000_00FF);
    wr(8'h40, 32'h0000_000F);
    check("R4 clear", pin_out[31:0], 96'h0000_00F0);
    wr(8'h30, 32'h0000_0000);
    check("R4 set zero bits", pin_out[31:0], 96'h0000_00F0);

    // R5 data load on bank 2
    wr(8'h28, 32'h1234_5678);
    check("R5 data load", pin_out, {32'h1234_5678, 32'h0, 32'h0000_00F0});

    // R6 data read with inversion (edges not enabled)
    pin_in[31:0] = 32'hA5A5_0001;
    idle(4);
    rd(8'h20, 32'hA5A5_0001, "R6 data read");
    wr(8'h10, 32'hFFFF_0000);
    idle(2);
    rd(8'h20, 32'h5A5A_0001, "R6 inverted read");
    rd(8'h10, 32'hFFFF_0000, "R2 inv readback");
    rd(8'h90, 32'h0, "R7 no enable no status");

    // R12 / R7 rising edge on pin 35
    wr(8'h54, 32'h0000_0008);
    @(negedge clk); pin_in[35] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R12 irq not before third edge", {95'h0, irq}, 96'h0);
    @(negedge clk); check("R12 irq on third edge", {95'h0, irq}, 96'h1);
    rd(8'h94, 32'h0000_0008, "R7 rising status");

    // R7 disabled kind / enabled falling on pin 64
    wr(8'h68, 32'h0000_0001);
    rd(8'h68, 32'h0000_0001, "R2 fall enable readback");
    pin_in[64] = 1'b1;
    idle(5);
    rd(8'h98, 32'h0, "R7 rising ignored when only falling enabled");
    pin_in[64] = 1'b0;
    idle(5);
    rd(8'h98, 32'h0000_0001, "R7 falling status");

    // R8 write-1-to-clear, R9 combined irq
    wr(8'h94, 32'h0);
    rd(8'h94, 32'h0000_0008, "R8 zero write keeps");
    wr(8'h98, 32'h0000_0001);
    rd(8'h98, 32'h0, "R8 clear bank2");
    check("R9 irq with bank1 pending", {95'h0, irq}, 96'h1);
    wr(8'h94, 32'h0000_0008);
    idle(1);
    check("R9 irq drops when all clear", {95'h0, irq}, 96'h0);

    // R10 clear and new edge in the same cycle
    wr(8'h64, 32'h0000_0008);
    @(negedge clk); pin_in[35] = 1'b0;
    idle(5);
    rd(8'h94, 32'h0000_0008, "R10 setup falling");
    @(negedge clk); pin_in[35] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h94; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(8'h94, 32'h0000_0008, "R10 edge wins over clear");
    check("R10 irq stays", {95'h0, irq}, 96'h1);
    wr(8'h94, 32'h0000_0008);

    // R11 reserved kinds and bank slot 3
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'hB4, 32'hFFFF_FFFF);
    rd(8'h70, 32'h0, "R11 high-level kind");
    rd(8'h80, 32'h0, "R11 low-level kind");
    rd(8'hA4, 32'h0, "R11 capture kind");
    rd(8'h0C, 32'h0, "R11 bank slot 3");
    check("R11 pin_oe untouched", pin_oe, {32'h0, 32'hF0F0_0000, 32'h0});
    check("R11 pin_out untouched", pin_out, {32'h1234_5678, 32'h0, 32'h0000_00F0});

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule